// File: doc/BRIEF.md
# Dual-Lane 32-bit SIMD Shifter

This block is a combinational shift datapath for a 64-bit operand. The operand is split into two 32-bit lanes: lane 1 holds bits [63:32] and lane 0 holds bits [31:0]. Each cycle, one operation is applied to both lanes at once, with the same shift amount for both. The six operations are:

- logical left shift
- logical right shift
- arithmetic right shift
- rounding logical right shift
- rounding arithmetic right shift
- saturating signed left shift

The result is available in the same cycle as the inputs. The saturating left shift limits each lane to the signed 32-bit range. When any lane saturates on a valid cycle, a sticky overflow flag is set. The flag is the block's only state. It stays set until a synchronous clear or a reset. The caller presents the low five bits of the immediate or register shift operand as the amount.

Top module: `simd32_shifter`

## Requirements
- R1: The two 32-bit lanes, bits [63:32] and bits [31:0], are shifted independently with the same 5-bit amount. A lane's result never depends on the other lane's bits.
- R2: Operation code 0 is logical left and code 1 is logical right. Both fill vacated bit positions with zero.
- R3: Operation code 2 is arithmetic right. Vacated positions take the lane's bit 31.
- R4: Operation codes 3 (logical) and 4 (arithmetic) are rounding right shifts. For a nonzero amount n, the lane is shifted right by n-1, zero- or sign-extended to 33 bits, incremented by 1, and then shifted right by one more bit. This adds one at the most significant discarded bit.
- R5: For every operation code 0 to 5, an amount of zero returns the source operand unchanged.
- R6: Operation code 5 is the saturating left shift, with the lane read as signed. An exact result above 2^31-1 gives 0x7FFFFFFF. An exact result below -2^31 gives 0x80000000. Any other result is the plain left shift.
- R7: The overflow flag is set at the next clock edge when valid is high, the code is 5 and any lane saturates. Cycles without valid, and cycles that do not saturate, leave the flag unchanged.
- R8: The overflow flag is cleared at the next clock edge by the clear input, which wins over a simultaneous set. The flag is also cleared by an active-low reset.
- R9: Operation codes 6 and 7 produce a zero result and leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overflow flag |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Qualifies the flag update for this cycle |
| clr_ov_i | input | 1 | Synchronous clear of the overflow flag |
| op_i | input | 3 | Operation code (0 to 5; 6 and 7 unused) |
| amt_i | input | 5 | Shift amount, 0 to 31 |
| src_i | input | 64 | Two packed 32-bit lanes |
| res_o | output | 64 | Shifted lanes, combinational |
| ov_o | output | 1 | Sticky saturation flag |

## Verification
The bench sweeps every operation code against amounts 0, 1, 4, 30 and 31, using sources whose lanes differ in sign and magnitude. Each of the following design errors would show up as a wrong result:

- A design that lets one lane's bits cross into the other would corrupt the result.
- A design that rounds at the wrong bit would be off by one on odd discarded halves.
- A design that shifts by zero through the rounding path would change a zero-amount operand.

The saturation cases include a positive and a negative lane that overflow by a single bit. They also include a negative lane that shifts without overflow, which a design that compares only magnitudes would flag falsely. The flag sequence checks four more faults:

- a set taken without valid
- a flag that a later clean shift drops
- a clear that loses to a simultaneous set
- unused codes that return data or touch the flag

// File: rtl/simd32_shifter.sv
module simd32_shifter #(
  parameter int LANE_W = 32,
  parameter int LANES  = 2,
  parameter int SA_W   = $clog2(LANE_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid_i,
  input  logic                    clr_ov_i,
  input  logic [2:0]              op_i,
  input  logic [SA_W-1:0]         amt_i,
  input  logic [LANES*LANE_W-1:0] src_i,
  output logic [LANES*LANE_W-1:0] res_o,
  output logic                    ov_o
);
  localparam int DW = LANES * LANE_W;
  localparam logic [2:0] OP_SLL = 3'd0, OP_SRL = 3'd1, OP_SRA = 3'd2,
                         OP_SRLU = 3'd3, OP_SRAU = 3'd4, OP_KSLL = 3'd5;

  logic [LANES-1:0] lane_sat;
  logic [SA_W-1:0]  sa_m1;

  assign sa_m1 = amt_i - SA_W'(1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0]   x, y;
    logic                sgn;
    logic [2*LANE_W-1:0] wide;
    logic [LANE_W-LANE_W/2*2+LANE_W:0] ext_l, ext_a, rnd_l, rnd_a;
    logic [LANE_W:LANE_W-1] unused_lo;
    logic                top_ones, top_zeros;

    assign x   = src_i[g*LANE_W +: LANE_W];
    assign sgn = x[LANE_W-1];

    assign wide      = {{LANE_W{sgn}}, x} << amt_i;
    assign top_ones  = &wide[2*LANE_W-1:LANE_W-1];
    assign top_zeros = ~|wide[2*LANE_W-1:LANE_W-1];
    assign lane_sat[g] = (amt_i != '0) && !(top_ones || top_zeros);

    assign ext_l = {1'b0, x} >> sa_m1;
    assign ext_a = $unsigned($signed({sgn, x}) >>> sa_m1);
    assign rnd_l = ext_l + 1'b1;
    assign rnd_a = ext_a + 1'b1;
    assign unused_lo = {rnd_l[0], rnd_a[0]};

    always_comb begin
      y = '0;
      if (amt_i == '0 && op_i <= OP_KSLL) y = x;
      else begin
        case (op_i)
          OP_SLL:  y = x << amt_i;
          OP_SRL:  y = x >> amt_i;
          OP_SRA:  y = $unsigned($signed(x) >>> amt_i);
          OP_SRLU: y = rnd_l[LANE_W:1];
          OP_SRAU: y = rnd_a[LANE_W:1];
          OP_KSLL: y = lane_sat[g] ? (sgn ? {1'b1, {(LANE_W-1){1'b0}}}
                                          : {1'b0, {(LANE_W-1){1'b1}}})
                                   : wide[LANE_W-1:0];
          default: y = '0;
        endcase
      end
    end

    assign res_o[g*LANE_W +: LANE_W] = y;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_ov_i) ov_o <= 1'b0;
    else if (valid_i && op_i == OP_KSLL && |lane_sat) ov_o <= 1'b1;
  end

  AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ov_o && !clr_ov_i |=> ov_o); // R7
  AST_OV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ov_i |=> !ov_o); // R8
  AST_OV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !ov_o && !(valid_i && op_i == OP_KSLL) |=> !ov_o); // R7
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    amt_i == '0 && op_i <= OP_KSLL |-> res_o == src_i); // R5
  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (!rst_n)
    op_i > OP_KSLL |-> res_o == '0); // R9
  AST_SRL_TOPZERO: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_SRL && amt_i != '0 |-> !res_o[DW-1] && !res_o[LANE_W-1]); // R2
endmodule

// File: tb/simd32_shifter_tb.sv
module simd32_shifter_tb_top;
  localparam int CLK_PER = 10;

  typedef struct {
    logic [63:0] res;
    logic        ov;
    string       tag;
  } exp_t;

  logic        clk = 0, rst_n = 0, valid_i = 0, clr_ov_i = 0;
  logic [2:0]  op_i = '0;
  logic [4:0]  amt_i = '0;
  logic [63:0] src_i = '0;
  logic [63:0] res_o;
  logic        ov_o;
  int checks = 0, fails = 0;
  logic model_ov = 0;
  exp_t q[$];
  bit done = 0;

  simd32_shifter dut_i (.clk(clk), .rst_n(rst_n), .valid_i(valid_i), .clr_ov_i(clr_ov_i),
    .op_i(op_i), .amt_i(amt_i), .src_i(src_i), .res_o(res_o), .ov_o(ov_o));

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [31:0] lane_model(input logic [2:0] op, input int sa,
                                             input logic [31:0] x, output bit sat);
    longint s, u, p;
    s = longint'($signed(x));
    u = longint'({32'b0, x});
    sat = 0;
    if (op > 5) return 32'h0;
    if (sa == 0) return x;
    case (op)
      3'd0: return 32'(u << sa);
      3'd1: return 32'(u >> sa);
      3'd2: return 32'(s >>> sa);
      3'd3: return 32'(((u >> (sa - 1)) + 1) >> 1);
      3'd4: return 32'(((s >>> (sa - 1)) + 1) >>> 1);
      default: begin
        p = s * (longint'(1) << sa);
        if (p > 64'sd2147483647) begin sat = 1; return 32'h7FFF_FFFF; end
        if (p < -64'sd2147483648) begin sat = 1; return 32'h8000_0000; end
        return 32'(p);
      end
    endcase
  endfunction

  task automatic drive(input logic [2:0] op, input logic [4:0] sa, input logic [63:0] src,
                       input logic v, input logic clr, input string tag);
    exp_t e;
    bit s0, s1;
    @(negedge clk);
    op_i = op; amt_i = sa; src_i = src; valid_i = v; clr_ov_i = clr;
    e.res = {lane_model(op, int'(sa), src[63:32], s1), lane_model(op, int'(sa), src[31:0], s0)};
    if (clr) model_ov = 0;
    else if (v && op == 3'd5 && (s0 || s1)) model_ov = 1;
    e.ov = model_ov;
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      #1;
      checks++;
      if (res_o !== e.res) begin
        fails++;
        $display("FAIL %s res actual=%h expected=%h", e.tag, res_o, e.res);
      end
      checks++;
      if (ov_o !== e.ov) begin
        fails++;
        $display("FAIL %s ov actual=%b expected=%b", e.tag, ov_o, e.ov);
      end
    end
  end

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] srcs[5];
    logic [4:0]  sas[5];
    srcs[0] = 64'h8000_0001_7FFF_FFFF;
    srcs[1] = 64'h1234_5678_FFFF_FFFF;
    srcs[2] = 64'hC000_0003_0000_0005;
    srcs[3] = 64'h4000_0000_BFFF_FFFF;
    srcs[4] = 64'hFFFF_FFF5_0000_000B;
    sas[0] = 5'd0; sas[1] = 5'd1; sas[2] = 5'd4; sas[3] = 5'd30; sas[4] = 5'd31;
    repeat (3) @(negedge clk);
    checks++;
    if (ov_o !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset ov actual=%b expected=0", ov_o);
    end
    rst_n = 1;
    // R7: no valid, saturating: flag stays clear
    drive(3'd5, 5'd1, 64'h4000_0000_0000_0001, 0, 0, "R7_novalid");
    // R6: single-bit overflow both signs; negative lane that fits
    drive(3'd5, 5'd1, 64'h4000_0000_0000_0001, 1, 0, "R6_pos_sat");
    drive(3'd5, 5'd1, 64'h0000_0000_0000_0001, 1, 0, "R7_sticky");
    drive(3'd5, 5'd0, 64'h7FFF_FFFF_8000_0000, 1, 1, "R8_clear");
    drive(3'd5, 5'd1, 64'hC000_0000_BFFF_FFFF, 1, 0, "R6_neg_sat");
    drive(3'd5, 5'd1, 64'hC000_0000_BFFF_FFFF, 1, 1, "R8_clear_wins");
    drive(3'd5, 5'd2, 64'hE000_0000_0000_0003, 1, 0, "R6_neg_fits");
    drive(3'd6, 5'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R9_op6");
    // R1: lanes independent
    drive(3'd0, 5'd4, 64'h0000_000F_F000_0000, 1, 0, "R1_left");
    drive(3'd1, 5'd4, 64'h0000_000F_F000_0000, 1, 0, "R1_right");
    drive(3'd2, 5'd4, 64'h0000_000F_F000_0000, 1, 0, "R3_sign_fill");
    drive(3'd3, 5'd1, 64'hFFFF_FFFF_0000_0003, 1, 0, "R4_round_log");
    drive(3'd4, 5'd1, 64'hFFFF_FFFD_0000_0003, 1, 0, "R4_round_ari");
    drive(3'd5, 5'd31, 64'h0000_0000_FFFF_FFFF, 1, 0, "R6_max_shift");
    drive(3'd7, 5'd0, 64'h1234_5678_9ABC_DEF0, 1, 0, "R9_op7");
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 5; a++)
        for (int s = 0; s < 5; s++)
          drive(3'(o), sas[a], srcs[s], 1, (o == 6), $sformatf("R%0s_sweep_op%0d",
                (a == 0) ? "5" : (o == 5 ? "6" : (o >= 3 && o <= 4 ? "4" : "2")), o));
    drive(3'd0, 5'd0, 64'h0, 0, 0, "R5_final");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule